// File: doc/BRIEF.md
# Flag Threshold Offset Loader

This block holds the two offset values that a FIFO's programmable flags compare against: an X offset for the almost-empty threshold and a Y offset for the almost-full threshold. While master reset is held low, three configuration inputs choose how those offsets are filled. They can take one of three fixed default values. They can be written in two steps from the write-side data bus. They can also be shifted in one bit at a time.

In serial mode, a bit is shifted into one chain formed by Y followed by X each time the active-low enable is low at a rising clock edge. The first bit ends up as the most significant bit of Y and the last bit as the least significant bit of X. A bit counter raises a done flag once the whole chain has been filled, and the value is frozen after that. A partial reset leaves the chosen method, the offsets and the done flag untouched. Flag comparison and FIFO storage sit outside this block.

Top module: `flo_loader`

## Requirements
- R1: Master reset is synchronous and active low (`mrst_n`), and the method is decoded at each clock edge while it is low. With `cfg_mode`=0 the method is preset: `cfg_sel`=00 loads 8, 01 loads 16, and 10 or 11 loads 64 into both X and Y. In preset mode `load_done` is 1 at the first edge after reset is released.
- R2: In serial mode (`cfg_mode`=1, `cfg_sel[0]`=0), each enabled bit is shifted into the chain {Y,X} from the low end. After 2*OFS_W bits, the first bit sent is Y[OFS_W-1] and the last bit sent is X[0].
- R3: In serial mode, `load_done` stays 0 until exactly 2*OFS_W enabled bits have been taken. It goes to 1 in the cycle the last bit is taken and stays 1 until the next master reset.
- R4: Once `load_done` is 1, further serial enables and parallel writes leave X and Y unchanged.
- R5: A clock edge with `sen_n` high and `pwr` low changes neither offset nor `load_done`.
- R6: In parallel mode (`cfg_mode`=1, `cfg_sel[0]`=1), the first edge with `pwr` high loads X from `pdata[OFS_W-1:0]`. The second such edge loads Y from the same bits and sets `load_done`.
- R7: While `prst_n` is low, the offsets, `load_done`, the loading progress and the method are all held, and serial enables and parallel writes are ignored. Loading continues from where it stopped once `prst_n` is high again.
- R8: Master reset in serial or parallel mode clears X, Y and `load_done` to 0. A later master reset decodes the method again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; method is decoded while low |
| prst_n | input | 1 | Partial reset, active low; all loader state is held |
| cfg_mode | input | 1 | 0: preset method, 1: serial or parallel loading |
| cfg_sel | input | 2 | Preset choice, or bit 0 picks parallel (1) over serial (0) |
| sen_n | input | 1 | Serial shift enable, active low |
| sdat | input | 1 | Serial data bit |
| pwr | input | 1 | Parallel write strobe, active high |
| pdata | input | DATA_W | Parallel data; the low OFS_W bits are used |
| ofs_x | output | OFS_W | Almost-empty offset |
| ofs_y | output | OFS_W | Almost-full offset |
| load_done | output | 1 | Offsets fully loaded |

## Verification
The serial chain is driven with an irregular 40-bit pattern that has no repeats, and the expected value is checked after every single bit, with idle gaps mixed in. This tells a correct shift direction and bit order apart from reversed or offset ones, and it shows whether the done flag rises one bit early or one bit late. Each of the four preset codes is tried, so every decode branch is covered. Parallel writes use different values for X and Y, so swapped targets are caught. Partial reset is pulsed both in the middle of a serial load and after it finishes, so a reset that clears progress is told apart from one that keeps it.

// File: rtl/flo_pkg.sv
package flo_pkg;
    typedef enum logic [1:0] {
        MTH_PRESET   = 2'd0,
        MTH_SERIAL   = 2'd1,
        MTH_PARALLEL = 2'd2
    } mth_e;

    localparam int unsigned PRESET_LO  = 8;
    localparam int unsigned PRESET_MID = 16;
    localparam int unsigned PRESET_HI  = 64;
endpackage

// File: rtl/flo_decode.sv
module flo_decode
    import flo_pkg::*;
#(
    parameter int unsigned OFS_W = 20
) (
    input  logic             cfg_mode,
    input  logic [1:0]       cfg_sel,
    output mth_e             mth,
    output logic [OFS_W-1:0] preset
);
    always_comb begin
        mth    = MTH_PRESET;
        preset = '0;
        if (cfg_mode) begin
            mth = cfg_sel[0] ? MTH_PARALLEL : MTH_SERIAL;
        end else begin
            unique case (cfg_sel)
                2'b00:   preset = OFS_W'(PRESET_LO);
                2'b01:   preset = OFS_W'(PRESET_MID);
                default: preset = OFS_W'(PRESET_HI);
            endcase
        end
    end
endmodule

// File: rtl/flo_bitcnt.sv
module flo_bitcnt #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && !full)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign full  = (cnt_q == limit);
endmodule

// File: rtl/flo_loader.sv
module flo_loader
    import flo_pkg::*;
#(
    parameter int unsigned OFS_W  = 20,
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              cfg_mode,
    input  logic [1:0]        cfg_sel,
    input  logic              sen_n,
    input  logic              sdat,
    input  logic              pwr,
    input  logic [DATA_W-1:0] pdata,
    output logic [OFS_W-1:0]  ofs_x,
    output logic [OFS_W-1:0]  ofs_y,
    output logic              load_done
);
    localparam int unsigned CHAIN_W = 2 * OFS_W;
    localparam int unsigned CNT_W   = $clog2(CHAIN_W + 1);

    typedef struct packed {
        mth_e             mth;
        logic [OFS_W-1:0] y;
        logic [OFS_W-1:0] x;
    } st_t;

    st_t              st_d, st_q;
    mth_e             dec_mth;
    logic [OFS_W-1:0] dec_preset;
    logic [CNT_W-1:0] cnt_lim, cnt_val;
    logic             cnt_clr, cnt_inc, cnt_full;
    logic [CHAIN_W-1:0] chain_cur, chain_nxt;

    flo_decode #(.OFS_W(OFS_W)) u_dec (
        .cfg_mode (cfg_mode),
        .cfg_sel  (cfg_sel),
        .mth      (dec_mth),
        .preset   (dec_preset)
    );

    flo_bitcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .limit (cnt_lim),
        .count (cnt_val),
        .full  (cnt_full)
    );

    // Y sits above X, so the first bit in travels to the top of Y
    assign chain_cur = {st_q.y, st_q.x};
    assign chain_nxt = {chain_cur[CHAIN_W-2:0], sdat};

    always_comb begin
        case (st_q.mth)
            MTH_SERIAL:   cnt_lim = CNT_W'(CHAIN_W);
            MTH_PARALLEL: cnt_lim = CNT_W'(2);
            default:      cnt_lim = '0;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        cnt_clr = !mrst_n;
        cnt_inc = 1'b0;
        if (!mrst_n) begin
            st_d.mth = dec_mth;
            st_d.x   = dec_preset;
            st_d.y   = dec_preset;
        end else if (prst_n && !cnt_full) begin
            case (st_q.mth)
                MTH_SERIAL: begin
                    if (!sen_n) begin
                        {st_d.y, st_d.x} = chain_nxt;
                        cnt_inc          = 1'b1;
                    end
                end
                MTH_PARALLEL: begin
                    if (pwr) begin
                        if (cnt_val == '0)
                            st_d.x = pdata[OFS_W-1:0];
                        else
                            st_d.y = pdata[OFS_W-1:0];
                        cnt_inc = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ofs_x     = st_q.x;
    assign ofs_y     = st_q.y;
    assign load_done = cnt_full;
endmodule

// File: rtl/flo_checker.sv
module flo_checker #(
    parameter int unsigned OFS_W = 20
) (
    input logic             clk,
    input logic             mrst_n,
    input logic             prst_n,
    input logic             sen_n,
    input logic             pwr,
    input logic [OFS_W-1:0] ofs_x,
    input logic [OFS_W-1:0] ofs_y,
    input logic             load_done
);
    a_r3_done_sticky: assert property (@(posedge clk) disable iff (!mrst_n)
        load_done |=> load_done);

    a_r4_frozen_when_done: assert property (@(posedge clk) disable iff (!mrst_n)
        load_done |=> ($stable(ofs_x) && $stable(ofs_y)));

    a_r5_idle_no_change: assert property (@(posedge clk) disable iff (!mrst_n)
        (sen_n && !pwr) |=> ($stable(ofs_x) && $stable(ofs_y) && $stable(load_done)));

    a_r7_partial_holds: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> ($stable(ofs_x) && $stable(ofs_y) && $stable(load_done)));
endmodule

bind flo_loader flo_checker #(.OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .sen_n     (sen_n),
    .pwr       (pwr),
    .ofs_x     (ofs_x),
    .ofs_y     (ofs_y),
    .load_done (load_done)
);

// File: tb/sim_flo_loader.sv
`timescale 1ns/1ps
module sim_flo_loader;
    localparam int W  = 20;
    localparam int DW = 36;
    localparam int CW = 2 * W;

    typedef struct {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic         d;
        string        tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1, cfg_mode = 1'b0;
    logic [1:0]    cfg_sel = 2'b00;
    logic          sen_n = 1'b1, sdat = 1'b0, pwr = 1'b0;
    logic [DW-1:0] pdata = '0;
    logic [W-1:0]  ofs_x, ofs_y;
    logic          load_done;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   fin   = 0;

    always #5 clk = ~clk;

    flo_loader #(.OFS_W(W), .DATA_W(DW)) u0 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_mode(cfg_mode),
        .cfg_sel(cfg_sel), .sen_n(sen_n), .sdat(sdat), .pwr(pwr), .pdata(pdata),
        .ofs_x(ofs_x), .ofs_y(ofs_y), .load_done(load_done)
    );

    // monitor: compares each queued expectation on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (ofs_x !== e.x || ofs_y !== e.y || load_done !== e.d) begin
                    bad++;
                    $display("FAIL %s: got x=%h y=%h done=%b, expected x=%h y=%h done=%b",
                             e.tag, ofs_x, ofs_y, load_done, e.x, e.y, e.d);
                end
            end
        end
    end

    task automatic push(input logic [W-1:0] x, input logic [W-1:0] y, input logic d, input string tag);
        exp_t e;
        e.x = x; e.y = y; e.d = d; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input logic en_n, input logic sd, input logic wr,
                        input logic [DW-1:0] pd, input logic prs);
        sen_n = en_n; sdat = sd; pwr = wr; pdata = pd; prst_n = prs;
        @(posedge clk);
        #1;
    endtask

    task automatic mreset(input logic mode, input logic [1:0] sel);
        mrst_n = 1'b0; cfg_mode = mode; cfg_sel = sel;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, '0, 1'b1);
        mrst_n = 1'b1;
    endtask

    localparam logic [CW-1:0] PAT = 40'hC35A96E17B;

    function automatic logic [CW-1:0] part(input int k);
        return PAT >> (CW - k);
    endfunction

    initial begin
        logic [CW-1:0] v;
        int k;
        // R1: every preset code, then R4: writes after done are ignored
        for (int s = 0; s < 4; s++) begin
            logic [W-1:0] pv;
            pv = (s == 0) ? W'(8) : (s == 1) ? W'(16) : W'(64);
            mreset(1'b0, 2'(s));
            push(pv, pv, 1'b1, "R1 preset decode");
            step(1'b0, 1'b1, 1'b1, '1, 1'b1);
            push(pv, pv, 1'b1, "R4 preset ignores writes");
        end

        // R8: serial reset clears; R2/R3/R5 bit by bit
        mreset(1'b1, 2'b00);
        push('0, '0, 1'b0, "R8 serial reset clears");
        k = 0;
        for (int i = 0; i < CW; i++) begin
            if (i % 7 == 3) begin
                step(1'b1, ~PAT[CW-1-i], 1'b0, '0, 1'b1);
                v = part(k);
                push(v[W-1:0], v[CW-1:W], 1'b0, "R5 enable high no shift");
            end
            step(1'b0, PAT[CW-1-i], 1'b0, '0, 1'b1);
            k++;
            v = part(k);
            push(v[W-1:0], v[CW-1:W], (k == CW), (k == CW) ? "R2 final order" : "R3 partial chain");
        end
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1, 1'b0, '0, 1'b1);
            push(PAT[W-1:0], PAT[CW-1:W], 1'b1, "R4 serial after done");
        end

        // R7: partial reset mid-load keeps progress and method
        mreset(1'b1, 2'b10);
        k = 0;
        for (int i = 0; i < 10; i++) begin step(1'b0, PAT[CW-1-i], 1'b0, '0, 1'b1); k++; end
        v = part(k);
        push(v[W-1:0], v[CW-1:W], 1'b0, "R2 ten bits in");
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1, 1'b1, '1, 1'b0);
            push(v[W-1:0], v[CW-1:W], 1'b0, "R7 partial reset holds");
        end
        for (int i = 10; i < CW; i++) step(1'b0, PAT[CW-1-i], 1'b0, '0, 1'b1);
        push(PAT[W-1:0], PAT[CW-1:W], 1'b1, "R7 resume after partial");
        step(1'b1, 1'b0, 1'b0, '0, 1'b0);
        push(PAT[W-1:0], PAT[CW-1:W], 1'b1, "R7 partial keeps done");

        // R6: parallel loading
        mreset(1'b1, 2'b01);
        push('0, '0, 1'b0, "R8 parallel reset clears");
        step(1'b0, 1'b1, 1'b0, 36'h0_FFFF_FFFF, 1'b1);
        push('0, '0, 1'b0, "R6 no strobe no load");
        step(1'b1, 1'b0, 1'b1, 36'h9_1234_5ABC, 1'b1);
        push(20'h45ABC, '0, 1'b0, "R6 first write to X");
        step(1'b1, 1'b0, 1'b1, 36'hF_0000_7E01, 1'b1);
        push(20'h45ABC, 20'h07E01, 1'b1, "R6 second write to Y");
        step(1'b1, 1'b0, 1'b1, 36'h5_5555_5555, 1'b1);
        push(20'h45ABC, 20'h07E01, 1'b1, "R4 parallel after done");

        // R8: new master reset decodes again
        mreset(1'b0, 2'b01);
        push(W'(16), W'(16), 1'b1, "R8 re-decode preset");

        @(negedge clk); @(negedge clk);
        fin = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule